// File: doc/BRIEF.md
# Auxiliary RAM bank steering

This block sits beside the address decoder of an 8-bit CPU system that has two 48K-plus RAM banks, a main bank and an auxiliary bank. For the address that is on the bus now, it reports whether a read should be served from the auxiliary bank and whether a write should land there. It keeps a small set of mode flags that software sets and clears by touching pairs of I/O addresses. The even address of a pair clears its flag and the odd address sets it.

Four address regions are steered:

- **Zero page and stack** (`$0000`–`$01FF`).
- **General RAM** (`$0200`–`$BFFF`).
- **Text display page** (`$0400`–`$07FF`).
- **High-resolution page** (`$2000`–`$3FFF`).

Reads and writes can be steered to different banks at the same time. The text page has a second steering mode that follows the display-page selector instead of the read/write flags.

The bank-select outputs are combinational from the bus address and the registered flags. A flag that changes at a clock edge first affects the bus cycle that follows that edge. Status reads put one flag on bit 7 of a data byte and also raise a hit strobe, so the surrounding read multiplexer knows to take the byte.

Top module: `aux_bank_sel`

## Requirements
- R1: A write cycle to `$C000/$C001` sets the text-store flag to address bit 0. The pairs `$C002/$C003` (read-aux flag), `$C004/$C005` (write-aux flag) and `$C008/$C009` (alternate-stack flag) behave the same way. The new value is seen from the next cycle on.
- R2: A read cycle to any address in `$C000`–`$C00F` leaves every flag unchanged.
- R3: In `$0200`–`$BFFF`, outside the text page, `rd_aux` equals the read-aux flag and `wr_aux` equals the write-aux flag, each independent of the other.
- R4: In `$0000`–`$01FF`, both `rd_aux` and `wr_aux` equal the alternate-stack flag, whatever the read-aux and write-aux flags hold.
- R5: In `$0400`–`$07FF` with the text-store flag set, both `rd_aux` and `wr_aux` equal the page-select flag.
- R6: In `$0400`–`$07FF` with the text-store flag clear, the text page follows the read-aux flag for reads and the write-aux flag for writes.
- R7: A read cycle or a write cycle to `$C054` clears the page-select flag, and one to `$C055` sets it.
- R8: A read cycle raises `stat_hit` and returns `stat_data` with the flag in bit 7 and all other bits zero at these addresses: `$C013` read-aux, `$C014` write-aux, `$C016` alternate stack, `$C018` text-store, `$C01C` page select. At any other address `stat_hit` is 0 and `stat_data` is 0.
- R9: Reset clears all five flags. At or above `$C000`, `rd_aux` and `wr_aux` are always 0.
- R10: The high-resolution page `$2000`–`$3FFF` follows the read-aux and write-aux flags even while the text-store flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | CPU address of the current cycle |
| bus_rd | input | 1 | Current cycle is a read |
| bus_wr | input | 1 | Current cycle is a write |
| rd_aux | output | 1 | A read at `bus_addr` is served from the auxiliary bank |
| wr_aux | output | 1 | A write at `bus_addr` goes to the auxiliary bank |
| stat_hit | output | 1 | `bus_addr` is a flag status location and a read is active |
| stat_data | output | DATA_W | Status byte, flag in the top bit |

## Verification
The bench builds the block with its default `DATA_W` of 8. With that width the status flag lands exactly on bit 7, so the `$80`/`$00` encodings can be compared directly. The stimulus moves the flags through combinations in which the read-aux and write-aux flags disagree. This exposes any crossing of the read and write paths in the general, high-resolution and text regions. It also sets the text-store flag with each value of the page-select flag, so both text-page steering modes are reached.

// File: rtl/aux_bank_sel.sv
module aux_bank_sel #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic              rd_aux,
  output logic              wr_aux,
  output logic              stat_hit,
  output logic [DATA_W-1:0] stat_data
);

  logic store80_q, rdalt_q, wralt_q, zpalt_q, page2_q;

  wire sw_blk   = (bus_addr[15:4] == 12'hC00);
  wire sw_wr    = bus_wr && sw_blk;
  wire pg_touch = (bus_rd || bus_wr) && (bus_addr[15:1] == 15'h602A);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store80_q <= 1'b0;
      rdalt_q   <= 1'b0;
      wralt_q   <= 1'b0;
      zpalt_q   <= 1'b0;
      page2_q   <= 1'b0;
    end else begin
      if (sw_wr) begin
        case (bus_addr[3:1])
          3'd0: store80_q <= bus_addr[0];
          3'd1: rdalt_q   <= bus_addr[0];
          3'd2: wralt_q   <= bus_addr[0];
          3'd4: zpalt_q   <= bus_addr[0];
          default: ;
        endcase
      end
      if (pg_touch) page2_q <= bus_addr[0];
    end
  end

  wire in_zp   = (bus_addr < 16'h0200);
  wire in_text = (bus_addr[15:10] == 6'b000001);
  wire in_gen  = !in_zp && (bus_addr < 16'hC000);

  assign rd_aux = in_zp               ? zpalt_q :
                  (in_text && store80_q) ? page2_q :
                  in_gen              ? rdalt_q : 1'b0;
  assign wr_aux = in_zp               ? zpalt_q :
                  (in_text && store80_q) ? page2_q :
                  in_gen              ? wralt_q : 1'b0;

  logic flag_sel;
  always_comb begin
    stat_hit = bus_rd;
    flag_sel = 1'b0;
    case (bus_addr)
      16'hC013: flag_sel = rdalt_q;
      16'hC014: flag_sel = wralt_q;
      16'hC016: flag_sel = zpalt_q;
      16'hC018: flag_sel = store80_q;
      16'hC01C: flag_sel = page2_q;
      default:  stat_hit = 1'b0;
    endcase
  end

  assign stat_data = stat_hit ? {flag_sel, {(DATA_W-1){1'b0}}} : '0;

  AST_RDALT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 16'hC003) |=> rdalt_q); // R1
  AST_SW_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && sw_blk) |=> ($stable(rdalt_q) && $stable(wralt_q) && $stable(zpalt_q) && $stable(store80_q))); // R2
  AST_STACK_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr < 16'h0200) |-> (rd_aux == wr_aux)); // R4
  AST_TEXT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (store80_q && bus_addr[15:10] == 6'b000001) |-> (rd_aux == wr_aux)); // R5
  AST_PAGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && bus_addr == 16'hC054) |=> !page2_q); // R7
  AST_STAT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stat_hit |-> (stat_data[DATA_W-2:0] == '0)); // R8
  AST_IO_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= 16'hC000) |-> (!rd_aux && !wr_aux)); // R9

endmodule

// File: tb/tb_aux_bank_sel.sv
module tb_aux_bank_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic        rd_aux, wr_aux, stat_hit;
  logic [7:0]  stat_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  aux_bank_sel #(.DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .rd_aux(rd_aux), .wr_aux(wr_aux), .stat_hit(stat_hit), .stat_data(stat_data)
  );

  // {chk, op(0 idle,1 rd,2 wr), addr, rd_aux, wr_aux, hit, stat, req}
  localparam int NV = 32;
  localparam logic [33:0] VEC [NV] = '{
    {1'b1, 2'd0, 16'h0300, 1'b0, 1'b0, 1'b0, 8'h00, 4'd9},  // R9
    {1'b1, 2'd0, 16'h0100, 1'b0, 1'b0, 1'b0, 8'h00, 4'd9},  // R9
    {1'b1, 2'd1, 16'hC018, 1'b0, 1'b0, 1'b1, 8'h00, 4'd8},  // R8
    {1'b0, 2'd2, 16'hC003, 1'b0, 1'b0, 1'b0, 8'h00, 4'd1},  // R1
    {1'b1, 2'd0, 16'h0300, 1'b1, 1'b0, 1'b0, 8'h00, 4'd3},  // R3
    {1'b1, 2'd0, 16'h2100, 1'b1, 1'b0, 1'b0, 8'h00, 4'd10}, // R10
    {1'b1, 2'd0, 16'h0500, 1'b1, 1'b0, 1'b0, 8'h00, 4'd6},  // R6
    {1'b1, 2'd1, 16'hC013, 1'b0, 1'b0, 1'b1, 8'h80, 4'd8},  // R8
    {1'b0, 2'd2, 16'hC005, 1'b0, 1'b0, 1'b0, 8'h00, 4'd1},  // R1
    {1'b1, 2'd0, 16'h0300, 1'b1, 1'b1, 1'b0, 8'h00, 4'd1},  // R1
    {1'b0, 2'd2, 16'hC002, 1'b0, 1'b0, 1'b0, 8'h00, 4'd1},  // R1
    {1'b1, 2'd0, 16'h8000, 1'b0, 1'b1, 1'b0, 8'h00, 4'd3},  // R3
    {1'b1, 2'd1, 16'hC014, 1'b0, 1'b0, 1'b1, 8'h80, 4'd8},  // R8
    {1'b1, 2'd1, 16'hC003, 1'b0, 1'b0, 1'b0, 8'h00, 4'd2},  // R2
    {1'b1, 2'd0, 16'h0300, 1'b0, 1'b1, 1'b0, 8'h00, 4'd2},  // R2
    {1'b0, 2'd2, 16'hC009, 1'b0, 1'b0, 1'b0, 8'h00, 4'd1},  // R1
    {1'b1, 2'd0, 16'h01FF, 1'b1, 1'b1, 1'b0, 8'h00, 4'd4},  // R4
    {1'b1, 2'd1, 16'hC016, 1'b0, 1'b0, 1'b1, 8'h80, 4'd8},  // R8
    {1'b0, 2'd2, 16'hC001, 1'b0, 1'b0, 1'b0, 8'h00, 4'd1},  // R1
    {1'b1, 2'd0, 16'h0400, 1'b0, 1'b0, 1'b0, 8'h00, 4'd5},  // R5
    {1'b1, 2'd1, 16'hC055, 1'b0, 1'b0, 1'b0, 8'h00, 4'd7},  // R7
    {1'b1, 2'd0, 16'h07FF, 1'b1, 1'b1, 1'b0, 8'h00, 4'd5},  // R5
    {1'b1, 2'd0, 16'h3FFF, 1'b0, 1'b1, 1'b0, 8'h00, 4'd10}, // R10
    {1'b1, 2'd1, 16'hC01C, 1'b0, 1'b0, 1'b1, 8'h80, 4'd7},  // R7
    {1'b0, 2'd2, 16'hC054, 1'b0, 1'b0, 1'b0, 8'h00, 4'd7},  // R7
    {1'b1, 2'd0, 16'h0400, 1'b0, 1'b0, 1'b0, 8'h00, 4'd7},  // R7
    {1'b1, 2'd1, 16'hC018, 1'b0, 1'b0, 1'b1, 8'h80, 4'd8},  // R8
    {1'b0, 2'd2, 16'hC000, 1'b0, 1'b0, 1'b0, 8'h00, 4'd1},  // R1
    {1'b1, 2'd0, 16'h0400, 1'b0, 1'b1, 1'b0, 8'h00, 4'd6},  // R6
    {1'b1, 2'd0, 16'h0800, 1'b0, 1'b1, 1'b0, 8'h00, 4'd3},  // R3
    {1'b1, 2'd0, 16'hC000, 1'b0, 1'b0, 1'b0, 8'h00, 4'd9},  // R9
    {1'b1, 2'd1, 16'hC017, 1'b0, 1'b0, 1'b0, 8'h00, 4'd8}   // R8
  };

  task automatic check(input int req, input logic er, input logic ew,
                       input logic eh, input logic [7:0] es);
    n_chk++;
    if (rd_aux !== er || wr_aux !== ew || stat_hit !== eh || stat_data !== es) begin
      n_bad++;
      $display("FAIL R%0d addr=%h got rd=%b wr=%b hit=%b st=%h exp rd=%b wr=%b hit=%b st=%h",
               req, bus_addr, rd_aux, wr_aux, stat_hit, stat_data, er, ew, eh, es);
    end
  endtask

  task automatic cycle(input logic [1:0] op, input logic [15:0] a);
    @(negedge clk);
    bus_addr = a;
    bus_rd   = (op == 2'd1);
    bus_wr   = (op == 2'd2);
    #5;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #50000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      cycle(VEC[i][32:31], VEC[i][30:15]);
      if (VEC[i][33])
        check(int'(VEC[i][3:0]), VEC[i][14], VEC[i][13], VEC[i][12], VEC[i][11:4]);
    end
    // R9: reset mid-run after setting every flag
    cycle(2'd2, 16'hC009);
    cycle(2'd2, 16'hC003);
    cycle(2'd2, 16'hC005);
    cycle(2'd2, 16'hC055);
    @(negedge clk);
    bus_wr = 1'b0;
    rst_n  = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    cycle(2'd0, 16'h0100);
    check(9, 1'b0, 1'b0, 1'b0, 8'h00);   // R9
    cycle(2'd0, 16'h0300);
    check(9, 1'b0, 1'b0, 1'b0, 8'h00);   // R9
    cycle(2'd1, 16'hC01C);
    check(9, 1'b0, 1'b0, 1'b1, 8'h00);   // R9
    // R4: alternate stack ignores the read-aux and write-aux flags
    cycle(2'd2, 16'hC003);
    cycle(2'd2, 16'hC005);
    cycle(2'd0, 16'h0000);
    check(4, 1'b0, 1'b0, 1'b0, 8'h00);   // R4
    cycle(2'd0, 16'h0200);
    check(3, 1'b1, 1'b1, 1'b0, 8'h00);   // R3
    // R2: read of a set address leaves the flag clear
    cycle(2'd1, 16'hC009);
    cycle(2'd0, 16'h0000);
    check(2, 1'b0, 1'b0, 1'b0, 8'h00);   // R2
    // R7: write to $C055 sets page select
    cycle(2'd2, 16'hC055);
    cycle(2'd1, 16'hC01C);
    check(7, 1'b0, 1'b0, 1'b1, 8'h80);   // R7
    @(negedge clk);
    bus_rd = 1'b0;
    finish_run();
  end
endmodule